// File: doc/BRIEF.md
# Vertical Format RAM Loader

This block fills the vertical-format table of a line printer from a byte stream delivered by a DMA data path. Each table entry is twelve bits wide and holds one stop bit per carriage channel for one line of the form. An entry is assembled from two consecutive data bytes, taking six bits from each. A load is framed by an opening code and a closing code. The block keeps the number of valid entries. An image that ends on half an entry is rejected by forcing that count to zero.

The carriage controller reads entries through a combinational read port. It also keeps its current line position in a format pointer held here. That pointer is returned to line 0 whenever a load closes. The table counts as usable (ready) whenever its valid length is nonzero. A transfer-start pulse puts the byte-pair tracker into an idle state, so stray data ahead of an opening code is dropped. A synchronous clear wipes the whole table.

Top module: `vfu_loader`

## Requirements
- R1: An accepted byte of value 8'hEC, 8'hED or 8'hEE is an opening code. It sets the valid length to 0 and puts the pair tracker in its even (first-half) phase. Table contents are kept.
- R2: An accepted byte 8'hEF is a closing code. It sets the format pointer to 0. If the tracker is in its odd phase at that moment, the length becomes 0. Otherwise the length is kept. The tracker phase is not changed by a closing code.
- R3: An accepted data byte (any other value) in the even phase keeps bits 5:0 as the low half of the next entry and moves the tracker to the odd phase. Bits 7:6 are ignored and no entry is written.
- R4: An accepted data byte in the odd phase writes the entry at index = length as {byte[5:0], held low half}. The length then increments by one and the tracker returns to the even phase.
- R5: The table holds 143 entries. A pair completed when the length is already 143 writes nothing and leaves the length at 143, but the phase still toggles for each byte.
- R6: A transfer-start pulse sets the tracker to idle. Any byte arriving in the same cycle is dropped. Data bytes seen while idle are ignored until an opening code arrives. Length, pointer and entries are kept.
- R7: vfu_ready is 1 exactly when the valid length is nonzero.
- R8: rd_entry combinationally returns the entry at rd_idx, or 0 when rd_idx ≥ 143. Bit n of an entry is the stop for channel n, and bit 0 marks top of form.
- R9: clear zeroes every entry, the length and the pointer, and sets the tracker to idle. It takes priority over every other input in that cycle.
- R10: ptr_wr loads ptr_wdata into the format pointer unless clear is asserted. A closing code accepted in the same cycle wins and the pointer becomes 0.
- R11: After reset the length, the pointer and all entries are 0, the tracker is idle and vfu_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous wipe of table, length and pointer |
| xfer_start | input | 1 | Start of a DMA transfer; tracker to idle |
| byte_vld | input | 1 | byte_data carries a stream byte this cycle |
| byte_data | input | 8 | Stream byte |
| ptr_wr | input | 1 | Carriage controller writes the format pointer |
| ptr_wdata | input | 8 | New format pointer value |
| rd_idx | input | 8 | Entry index for the read port |
| rd_entry | output | 12 | Entry at rd_idx (combinational) |
| fmt_len | output | 8 | Valid entry count |
| fmt_ptr | output | 8 | Format pointer |
| vfu_ready | output | 1 | Table usable (length nonzero) |

## Verification
The hardest state to reach is the full table. There, completed pairs must be thrown away while the phase keeps toggling, and that hidden phase can only be seen through what a later closing code does to the length. The bench streams an opening code and 145 pairs, then confirms the length stays at 143 and the last entry is intact. It then closes and sends one lone data byte followed by a second closing code: the length must drop to 0, which proves both that the overflow pairs toggled the phase and that the closing code left it alone. A behavioural model tracks every byte and compares length, pointer, ready and a sweeping read index on every clock.

// File: rtl/vfu_pkg.sv
package vfu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EVEN = 2'd1,
    PH_ODD  = 2'd2
  } pair_phase_e;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_CLOSE = 2'd2,
    BK_DATA  = 2'd3
  } byte_kind_e;

  localparam logic [7:0] CODE_OPEN_LO = 8'hEC;
  localparam logic [7:0] CODE_OPEN_HI = 8'hEE;
  localparam logic [7:0] CODE_CLOSE   = 8'hEF;
endpackage

// File: rtl/vfu_byte_decode.sv
module vfu_byte_decode
  import vfu_pkg::*;
(
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output byte_kind_e kind
);
  always_comb begin
    kind = BK_NONE;
    if (byte_vld) begin
      if (byte_data >= CODE_OPEN_LO && byte_data <= CODE_OPEN_HI) kind = BK_OPEN;
      else if (byte_data == CODE_CLOSE)                           kind = BK_CLOSE;
      else                                                        kind = BK_DATA;
    end
  end
endmodule

// File: rtl/vfu_pair_tracker.sv
module vfu_pair_tracker
  import vfu_pkg::*;
#(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              xfer_start,
  input  byte_kind_e        kind,
  input  logic [HALF_W-1:0] half_in,
  output pair_phase_e       phase_o,
  output logic [HALF_W-1:0] low_o,
  output logic              pair_done
);
  pair_phase_e       phase_q, phase_d;
  logic [HALF_W-1:0] low_q, low_d;
  logic              low_en;
  logic              accept;

  assign accept = !clear && !xfer_start;

  always_comb begin
    phase_d   = phase_q;
    low_d     = low_q;
    low_en    = 1'b0;
    pair_done = 1'b0;
    if (clear || xfer_start) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (kind)
        BK_OPEN: phase_d = PH_EVEN;
        BK_DATA: begin
          if (phase_q == PH_EVEN) begin
            low_d   = half_in;
            low_en  = 1'b1;
            phase_d = PH_ODD;
          end else if (phase_q == PH_ODD) begin
            pair_done = 1'b1;
            phase_d   = PH_EVEN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  assign phase_o = phase_q;
  assign low_o   = low_q;

  AST_IDLE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !clear) |=> (phase_q == PH_IDLE)); // R6
  AST_ODD_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == BK_DATA && phase_q == PH_EVEN) |=> (phase_q == PH_ODD)); // R3
endmodule

// File: rtl/vfu_len_ctrl.sv
module vfu_len_ctrl
  import vfu_pkg::*;
#(
  parameter int DEPTH = 143,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             xfer_start,
  input  byte_kind_e       kind,
  input  pair_phase_e      phase,
  input  logic             pair_done,
  input  logic             ptr_wr,
  input  logic [IDX_W-1:0] ptr_wdata,
  output logic [IDX_W-1:0] len_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);

  logic [IDX_W-1:0] len_q, len_d, ptr_q, ptr_d;
  logic             len_en, ptr_en, accept, has_room;

  assign accept   = !clear && !xfer_start;
  assign has_room = (len_q < DEPTH_L);

  always_comb begin
    len_d  = len_q;
    len_en = 1'b0;
    wr_en  = 1'b0;
    if (clear) begin
      len_d  = '0;
      len_en = 1'b1;
    end else if (accept) begin
      if (kind == BK_OPEN) begin
        len_d  = '0;
        len_en = 1'b1;
      end else if (kind == BK_CLOSE && phase == PH_ODD) begin
        len_d  = '0;
        len_en = 1'b1;
      end else if (pair_done && has_room) begin
        wr_en  = 1'b1;
        len_d  = len_q + 1'b1;
        len_en = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (clear) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (accept && kind == BK_CLOSE) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (ptr_wr) begin
      ptr_d  = ptr_wdata;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign wr_idx = len_q;
  assign len_o  = len_q;
  assign ptr_o  = ptr_q;

  AST_OPEN_ZEROES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == BK_OPEN) |=> (len_q == '0)); // R1
  AST_CLOSE_HOMES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == BK_CLOSE) |=> (ptr_q == '0)); // R2
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= DEPTH_L)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == DEPTH_L && pair_done) |=> (len_q == DEPTH_L)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (len_q == '0 && ptr_q == '0)); // R9
endmodule

// File: rtl/vfu_store.sv
module vfu_store #(
  parameter int DEPTH   = 143,
  parameter int ENTRY_W = 12,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);

  logic [ENTRY_W-1:0] ent_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q, ent_d;
    logic               ent_en;

    always_comb begin
      ent_en = 1'b0;
      ent_d  = ent_q;
      if (clear) begin
        ent_en = 1'b1;
        ent_d  = '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_en = 1'b1;
        ent_d  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ent_view[g] = ent_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx < DEPTH_L) rd_data = ent_view[rd_idx];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < DEPTH_L)); // R5
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ent_view[0] == '0 && ent_view[DEPTH-1] == '0)); // R9
endmodule

// File: rtl/vfu_loader.sv
module vfu_loader
  import vfu_pkg::*;
#(
  parameter int DEPTH  = 143,
  parameter int HALF_W = 6,
  parameter int IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                xfer_start,
  input  logic                byte_vld,
  input  logic [7:0]          byte_data,
  input  logic                ptr_wr,
  input  logic [IDX_W-1:0]    ptr_wdata,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [2*HALF_W-1:0] rd_entry,
  output logic [IDX_W-1:0]    fmt_len,
  output logic [IDX_W-1:0]    fmt_ptr,
  output logic                vfu_ready
);
  localparam int ENTRY_W = 2 * HALF_W;

  byte_kind_e        kind;
  pair_phase_e       phase;
  logic [HALF_W-1:0] low_half;
  logic              pair_done, wr_en;
  logic [IDX_W-1:0]  wr_idx;

  vfu_byte_decode u_dec (
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .kind     (kind)
  );

  vfu_pair_tracker #(.HALF_W(HALF_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .xfer_start(xfer_start),
    .kind      (kind),
    .half_in   (byte_data[HALF_W-1:0]),
    .phase_o   (phase),
    .low_o     (low_half),
    .pair_done (pair_done)
  );

  vfu_len_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .xfer_start(xfer_start),
    .kind      (kind),
    .phase     (phase),
    .pair_done (pair_done),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .len_o     (fmt_len),
    .ptr_o     (fmt_ptr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
  );

  vfu_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data({byte_data[HALF_W-1:0], low_half}),
    .rd_idx (rd_idx),
    .rd_data(rd_entry)
  );

  assign vfu_ready = (fmt_len != '0);

  AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !vfu_ready); // R7
endmodule

// File: tb/tb_vfu_loader.sv
`timescale 1ns/1ps
module tb_vfu_loader;
  localparam int DEPTH = 143;

  logic        clk = 1'b0;
  logic        rst_n, clear, xfer_start, byte_vld, ptr_wr;
  logic [7:0]  byte_data, ptr_wdata, rd_idx;
  logic [11:0] rd_entry;
  logic [7:0]  fmt_len, fmt_ptr;
  logic        vfu_ready;

  vfu_loader dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .xfer_start(xfer_start),
    .byte_vld(byte_vld), .byte_data(byte_data), .ptr_wr(ptr_wr),
    .ptr_wdata(ptr_wdata), .rd_idx(rd_idx), .rd_entry(rd_entry),
    .fmt_len(fmt_len), .fmt_ptr(fmt_ptr), .vfu_ready(vfu_ready)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference: phase 0 idle, 1 even, 2 odd
  int m_len = 0, m_ptr = 0, m_ph = 0, m_low = 0;
  int m_ram [DEPTH];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(int idx);
    return (idx < DEPTH) ? m_ram[idx] : 0;
  endfunction

  task automatic model_step();
    int b = byte_data;
    if (clear) begin
      foreach (m_ram[i]) m_ram[i] = 0;
      m_len = 0; m_ptr = 0; m_ph = 0;
    end else begin
      if (ptr_wr) m_ptr = ptr_wdata;
      if (xfer_start) m_ph = 0;
      else if (byte_vld) begin
        if (b >= 'hEC && b <= 'hEE) begin m_len = 0; m_ph = 1; end
        else if (b == 'hEF) begin m_ptr = 0; if (m_ph == 2) m_len = 0; end
        else if (m_ph == 1) begin m_low = b & 63; m_ph = 2; end
        else if (m_ph == 2) begin
          if (m_len < DEPTH) begin
            m_ram[m_len] = ((b & 63) << 6) | m_low;
            m_len++;
          end
          m_ph = 1;
        end
      end
    end
  endtask

  task automatic compare_all();
    chk(fmt_len == m_len[7:0], "R4 length", fmt_len, m_len);
    chk(fmt_ptr == m_ptr[7:0], "R10 pointer", fmt_ptr, m_ptr);
    chk(vfu_ready == (m_len != 0), "R7 ready", vfu_ready, m_len != 0);
    chk(rd_entry == m_read(rd_idx), "R8 read port", rd_entry, m_read(rd_idx));
  endtask

  // one clock: inputs already driven after a negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    byte_vld = 0; xfer_start = 0; clear = 0; ptr_wr = 0;
  endtask

  task automatic send(int b);
    byte_vld = 1; byte_data = b[7:0]; cyc();
  endtask

  task automatic peek(int idx, int exp, string tag);
    rd_idx = idx[7:0]; #1;
    chk(rd_entry == exp[11:0], tag, rd_entry, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (m_ram[i]) m_ram[i] = 0;
    rst_n = 0; clear = 0; xfer_start = 0; byte_vld = 0; byte_data = 0;
    ptr_wr = 0; ptr_wdata = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(fmt_len == 0, "R11 len", fmt_len, 0);
    chk(fmt_ptr == 0, "R11 ptr", fmt_ptr, 0);
    chk(vfu_ready == 0, "R11 ready", vfu_ready, 0);
    peek(0, 0, "R11 entry0");
    rst_n = 1;
    @(negedge clk);

    // R6 data before opening code is ignored
    xfer_start = 1; cyc();
    send('h05); send('h06); send('h07); send('h08);
    chk(fmt_len == 0, "R6 idle ignore", fmt_len, 0);

    // R1 R3 R4 basic pairs
    send('hEC);
    send('hC1); send('h82);           // bits 7:6 ignored -> 12'h081
    chk(fmt_len == 1, "R4 len after pair", fmt_len, 1);
    send('h3F); send('h3F);           // 12'hFFF
    send('h01); send('h00);           // 12'h001 top of form
    send('h15);                       // half entry only
    chk(fmt_len == 3, "R3 half does not write", fmt_len, 3);
    peek(0, 'h081, "R3 upper bits ignored");
    peek(1, 'hFFF, "R4 full entry");
    peek(2, 'h001, "R8 bit0 top of form");
    peek(3, 0, "R3 no write on even byte");
    send('h2A);                       // completes 12'hA95
    peek(3, 'hA95, "R4 assembled order");
    ptr_wdata = 8'd5; ptr_wr = 1; cyc();
    chk(fmt_ptr == 5, "R10 ptr write", fmt_ptr, 5);
    ptr_wdata = 8'd9; ptr_wr = 1; byte_vld = 1; byte_data = 8'hEF; cyc();
    chk(fmt_ptr == 0, "R10 close wins", fmt_ptr, 0);
    chk(fmt_len == 4, "R2 even close keeps", fmt_len, 4);

    // R2 odd image invalid
    send('hED); send('h11); send('hEF);
    chk(fmt_len == 0, "R2 odd close invalid", fmt_len, 0);
    chk(vfu_ready == 0, "R7 not ready", vfu_ready, 0);

    // R5 overflow of the table
    send('hEE);
    for (int i = 0; i < DEPTH + 2; i++) begin
      rd_idx = 8'((i * 3) % 150);
      send((i * 7 + 3) & 63);
      send(((i * 5 + 1) & 63) | 'h40);
    end
    chk(fmt_len == DEPTH, "R5 len capped", fmt_len, DEPTH);
    peek(DEPTH - 1, ((((DEPTH - 1) * 5 + 1) & 63) << 6) | (((DEPTH - 1) * 7 + 3) & 63),
         "R5 last entry intact");
    peek(200, 0, "R8 out of range reads zero");
    send('hEF);
    chk(fmt_len == DEPTH, "R5 phase toggled on discard", fmt_len, DEPTH);
    send('h09); send('hEF);
    chk(fmt_len == 0, "R2 close keeps phase", fmt_len, 0);

    // R6 transfer start drops same-cycle byte and later data
    send('hEC); send('h01); send('h02);
    xfer_start = 1; byte_vld = 1; byte_data = 8'hEC; cyc();
    chk(fmt_len == 1, "R6 same-cycle byte dropped", fmt_len, 1);
    send('h03); send('h04);
    chk(fmt_len == 1, "R6 idle after transfer start", fmt_len, 1);
    peek(0, 'h081, "R6 entry kept");

    // R9 clear beats a byte
    ptr_wdata = 8'd7; ptr_wr = 1; cyc();
    clear = 1; byte_vld = 1; byte_data = 8'hEC; ptr_wr = 1; cyc();
    chk(fmt_len == 0, "R9 len", fmt_len, 0);
    chk(fmt_ptr == 0, "R9 ptr", fmt_ptr, 0);
    peek(0, 0, "R9 entry0 wiped");
    peek(DEPTH - 1, 0, "R9 last wiped");
    send('h01); send('h02);
    chk(fmt_len == 0, "R9 tracker idle", fmt_len, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule